// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which of three operating modes a digital PLL channel is in: Free-Run, Locked or Holdover. It watches the channel's reference selection status and the events that take the channel away from its current reference. A 3-bit control field written by software either lets the block choose the mode by itself (automatic) or pins it to one mode (forced).

In automatic operation the channel starts in Free-Run and moves to Locked once a reference is selected. Any event that moves the channel off its reference sends it to Holdover. These events are disqualification, a revertive switch, a forced selection change, or a lock-to-other-channel change while the channel follows the other channel. Holdover then resolves to Locked if a reference is selected, or to Free-Run if none is.

The current mode is reported as a 2-bit status code. Each mode change produces a one-cycle pulse. That pulse can latch a sticky interrupt flag, which a write-one-to-clear strobe resets.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the status is Free-Run (00), the change pulse is 0 and the interrupt flag is 0.
- R2: The status code is 00 for Free-Run, 01 for Locked and 10 for Holdover, and is never 11.
- R3: In automatic mode (control 000), Free-Run moves to Locked on the clock edge where the selected indication is 1. Otherwise it stays in Free-Run.
- R4: In automatic mode, Locked moves to Holdover on the edge where any of these is 1: disqualification, revertive switch, or forced switch. It does the same when the other-channel switch is 1 while the track-other input is 1. The other-channel switch with track-other at 0 leaves Locked unchanged.
- R5: In Locked, a switch-away event and a selected indication in the same cycle give Holdover.
- R6: In automatic mode, Holdover moves to Locked if the selected indication is 1 and to Free-Run if it is 0.
- R7: Control 001 forces Free-Run, 010 forces Holdover and 100 forces Locked on the next clock edge, whatever the selection and switch inputs do.
- R8: Control codes 011, 101, 110 and 111 act as automatic. On return to any automatic code, operation continues from the state the forced mode left.
- R9: The change pulse is 1 for exactly the first cycle in which a new status value is shown, and 0 otherwise.
- R10: The interrupt flag is set when the change pulse rises while the enable is 1. It stays set until the clear strobe is 1 on an edge with no new change. A change on the same edge as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeCtrl | input | 3 | Software mode control field |
| clkSelected | input | 1 | A reference input clock is currently selected |
| selDisqualified | input | 1 | The selected reference lost qualification |
| revertSwitch | input | 1 | A higher-priority qualified clock was switched to |
| forcedSwitch | input | 1 | Selection changed by forced selection |
| otherChanSwitch | input | 1 | Selection changed via the lock-to-other-channel control |
| trackOtherChan | input | 1 | The channel follows the other channel's output |
| irqEnable | input | 1 | Lets a mode change set the interrupt flag |
| irqClear | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| modeStatus | output | 2 | Current mode code |
| changePulse | output | 1 | One-cycle mode-change pulse |
| irqStatus | output | 1 | Sticky mode-change interrupt flag |

## Verification
The bench builds the block with its default parameters: a 3-bit control field, forced codes 001, 010 and 100, and a 2-bit status. With these values every control code, including the four unused ones, can be driven and observed. A behavioural model steps through every transition of the mode graph, each switch-away event alone and together with a selected indication, and set/clear collisions on the interrupt flag.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

  localparam int STATUS_W = 2;

  typedef enum logic [STATUS_W-1:0] {
    MODE_FREE   = 2'b00,
    MODE_LOCKED = 2'b01,
    MODE_HOLD   = 2'b10
  } mode_e;

  // strobes from the control FSM to the flag datapath
  typedef struct packed {
    logic  modeChanged;
    mode_e newMode;
  } fsm_strobe_t;

endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
#(
  parameter int CTRL_W = 3,
  parameter logic [CTRL_W-1:0] CODE_AUTO   = 3'b000,
  parameter logic [CTRL_W-1:0] CODE_FREE   = 3'b001,
  parameter logic [CTRL_W-1:0] CODE_HOLD   = 3'b010,
  parameter logic [CTRL_W-1:0] CODE_LOCKED = 3'b100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] modeCtrl,
  input  logic              clkSelected,
  input  logic              selDisqualified,
  input  logic              revertSwitch,
  input  logic              forcedSwitch,
  input  logic              otherChanSwitch,
  input  logic              trackOtherChan,
  output mode_e             curMode,
  output fsm_strobe_t       strobe
);

  localparam int N_EVT = 4;

  mode_e           state, nextState;
  logic [N_EVT-1:0] awayEvt;
  logic            switchedAway;
  logic            forceFree, forceHold, forceLocked, autoMode;

  assign awayEvt      = {selDisqualified, revertSwitch, forcedSwitch,
                         otherChanSwitch & trackOtherChan};
  assign switchedAway = |awayEvt;

  assign forceFree   = (modeCtrl == CODE_FREE);
  assign forceHold   = (modeCtrl == CODE_HOLD);
  assign forceLocked = (modeCtrl == CODE_LOCKED);
  assign autoMode    = !(forceFree || forceHold || forceLocked);

  always_comb begin
    nextState = state;
    if (forceFree)        nextState = MODE_FREE;
    else if (forceHold)   nextState = MODE_HOLD;
    else if (forceLocked) nextState = MODE_LOCKED;
    else begin
      unique case (state)
        MODE_FREE:   if (clkSelected) nextState = MODE_LOCKED;
        MODE_LOCKED: if (switchedAway) nextState = MODE_HOLD;
        MODE_HOLD:   nextState = clkSelected ? MODE_LOCKED : MODE_FREE;
        default:     nextState = MODE_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_FREE;
    else       state <= nextState;
  end

  assign curMode             = state;
  assign strobe.modeChanged  = (nextState != state);
  assign strobe.newMode      = nextState;

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'b11);

  assert_forced_free_R7: assert property (@(posedge clk) disable iff (!rstN)
    forceFree |=> state == MODE_FREE);

  assert_forced_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    forceHold |=> state == MODE_HOLD);

  assert_forced_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    forceLocked |=> state == MODE_LOCKED);

  assert_away_to_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && state == MODE_LOCKED && (selDisqualified || revertSwitch || forcedSwitch))
      |=> state == MODE_HOLD);

  assert_hold_resolves_R6: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && state == MODE_HOLD) |=> state != MODE_HOLD);

  assert_free_waits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && state == MODE_FREE && !clkSelected) |=> state == MODE_FREE);

endmodule

// File: rtl/dpll_mode_flags.sv
module dpll_mode_flags
  import dpll_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  fsm_strobe_t strobe,
  input  logic        irqEnable,
  input  logic        irqClear,
  output logic        changePulse,
  output logic        irqStatus
);

  logic irqSet;

  assign irqSet = strobe.modeChanged & irqEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      changePulse <= 1'b0;
      irqStatus   <= 1'b0;
    end else begin
      changePulse <= strobe.modeChanged;
      irqStatus   <= irqSet | (irqStatus & ~irqClear);
    end
  end

  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.modeChanged && irqEnable) |=> irqStatus);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !strobe.modeChanged) |=> !irqStatus);

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus && !irqClear) |=> irqStatus);

  assert_pulse_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.modeChanged |=> !changePulse);

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int CTRL_W = 3,
  parameter logic [CTRL_W-1:0] CODE_AUTO   = 3'b000,
  parameter logic [CTRL_W-1:0] CODE_FREE   = 3'b001,
  parameter logic [CTRL_W-1:0] CODE_HOLD   = 3'b010,
  parameter logic [CTRL_W-1:0] CODE_LOCKED = 3'b100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] modeCtrl,
  input  logic              clkSelected,
  input  logic              selDisqualified,
  input  logic              revertSwitch,
  input  logic              forcedSwitch,
  input  logic              otherChanSwitch,
  input  logic              trackOtherChan,
  input  logic              irqEnable,
  input  logic              irqClear,
  output logic [STATUS_W-1:0] modeStatus,
  output logic              changePulse,
  output logic              irqStatus
);

  mode_e       curMode;
  fsm_strobe_t strobe;

  dpll_mode_fsm #(
    .CTRL_W(CTRL_W), .CODE_AUTO(CODE_AUTO), .CODE_FREE(CODE_FREE),
    .CODE_HOLD(CODE_HOLD), .CODE_LOCKED(CODE_LOCKED)
  ) i_fsm (
    .clk(clk), .rstN(rstN), .modeCtrl(modeCtrl),
    .clkSelected(clkSelected), .selDisqualified(selDisqualified),
    .revertSwitch(revertSwitch), .forcedSwitch(forcedSwitch),
    .otherChanSwitch(otherChanSwitch), .trackOtherChan(trackOtherChan),
    .curMode(curMode), .strobe(strobe)
  );

  dpll_mode_flags i_flags (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .irqEnable(irqEnable), .irqClear(irqClear),
    .changePulse(changePulse), .irqStatus(irqStatus)
  );

  assign modeStatus = curMode;

  assert_pulse_marks_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    changePulse |-> modeStatus != $past(modeStatus));

endmodule

// File: tb/test_dpll_mode_ctrl.sv
module test_dpll_mode_ctrl;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] modeCtrl;
  logic       clkSelected, selDisqualified, revertSwitch, forcedSwitch;
  logic       otherChanSwitch, trackOtherChan, irqEnable, irqClear;
  logic [1:0] modeStatus;
  logic       changePulse, irqStatus;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [1:0] mState;
  logic       mPulse, mIrq;

  always #2.5 clk = ~clk;

  dpll_mode_ctrl i_dpll_mode_ctrl (
    .clk(clk), .rstN(rstN), .modeCtrl(modeCtrl),
    .clkSelected(clkSelected), .selDisqualified(selDisqualified),
    .revertSwitch(revertSwitch), .forcedSwitch(forcedSwitch),
    .otherChanSwitch(otherChanSwitch), .trackOtherChan(trackOtherChan),
    .irqEnable(irqEnable), .irqClear(irqClear),
    .modeStatus(modeStatus), .changePulse(changePulse), .irqStatus(irqStatus)
  );

  // behavioural model, one step per rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 2'd0; mPulse = 1'b0; mIrq = 1'b0;
    end else begin
      logic [1:0] ns;
      bit away;
      away = selDisqualified || revertSwitch || forcedSwitch ||
             (otherChanSwitch && trackOtherChan);
      ns = mState;
      if (modeCtrl == 3'd1) ns = 2'd0;
      else if (modeCtrl == 3'd2) ns = 2'd2;
      else if (modeCtrl == 3'd4) ns = 2'd1;
      else if (mState == 2'd0) begin if (clkSelected) ns = 2'd1; end
      else if (mState == 2'd1) begin if (away) ns = 2'd2; end
      else ns = clkSelected ? 2'd1 : 2'd0;
      mPulse = (ns != mState);
      mIrq   = (mPulse && irqEnable) || (mIrq && !irqClear);
      mState = ns;
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // advance one cycle, then compare all outputs at the falling edge
  task automatic tick(input string tag);
    @(negedge clk);
    cmp(tag, "modeStatus", modeStatus, mState);
    cmp(tag, "changePulse", changePulse, mPulse);
    cmp(tag, "irqStatus", irqStatus, mIrq);
  endtask

  task automatic clearEvt();
    selDisqualified = 0; revertSwitch = 0; forcedSwitch = 0; otherChanSwitch = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; modeCtrl = 3'b000; clkSelected = 0; clearEvt();
    trackOtherChan = 0; irqEnable = 1; irqClear = 0;
    repeat (3) @(negedge clk);
    cmp("R1", "reset modeStatus", modeStatus, 0);
    cmp("R1", "reset changePulse", changePulse, 0);
    cmp("R1", "reset irqStatus", irqStatus, 0);
    rstN = 1;
    tick("R1");

    // R3: free-run waits, then locks
    repeat (3) tick("R3");
    clkSelected = 1; tick("R3");
    tick("R9");
    irqClear = 1; tick("R10"); irqClear = 0; tick("R10");

    // R4 / R5 / R6: each away event with clock still selected
    selDisqualified = 1; tick("R5"); clearEvt(); tick("R6");
    revertSwitch = 1;    tick("R4"); clearEvt(); tick("R6");
    forcedSwitch = 1;    tick("R4"); clearEvt(); tick("R6");
    otherChanSwitch = 1; tick("R4"); tick("R4"); clearEvt();
    trackOtherChan = 1; otherChanSwitch = 1; tick("R4"); clearEvt(); trackOtherChan = 0;
    clkSelected = 0; tick("R6"); tick("R6");

    // R10: disabled, collision of set and clear
    irqClear = 1; tick("R10"); irqClear = 0;
    irqEnable = 0; clkSelected = 1; tick("R10"); tick("R10");
    irqEnable = 1; irqClear = 1; selDisqualified = 1; tick("R10");
    clearEvt(); irqClear = 0; tick("R10"); tick("R10");

    // R7: forced modes ignore events
    modeCtrl = 3'b001; selDisqualified = 1; tick("R7"); tick("R7"); clearEvt();
    modeCtrl = 3'b010; tick("R7"); tick("R7");
    clkSelected = 0;
    modeCtrl = 3'b100; tick("R7"); revertSwitch = 1; tick("R7"); clearEvt();
    modeCtrl = 3'b010; tick("R7");

    // R8: resume from current state, unused codes act as automatic
    modeCtrl = 3'b000; clkSelected = 1; tick("R8"); tick("R8");
    modeCtrl = 3'b111; forcedSwitch = 1; tick("R8"); clearEvt(); clkSelected = 0; tick("R8");
    modeCtrl = 3'b011; tick("R8"); clkSelected = 1; tick("R8");
    modeCtrl = 3'b101; revertSwitch = 1; tick("R8"); clearEvt(); tick("R8");
    modeCtrl = 3'b110; tick("R8");
    modeCtrl = 3'b100; tick("R7");
    modeCtrl = 3'b000; tick("R2"); tick("R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule